// File: doc/BRIEF.md
# Memory Port Request Issuer

This block issues read and write requests for one client port of a multi-port memory controller. It runs on the controller's memory clock at a 1:1 ratio and has no clock of its own. A local command carries a byte address, a direction, a transfer-size code and a flag that says whether every byte enable of the write will be set. The block checks the command and registers it onto a request/acknowledge address phase. It holds the request steady until the controller returns a one-cycle acknowledge. If a second command is already waiting when the acknowledge arrives, that command is issued back to back.

When ECC is configured, the block works out whether a write needs a read-modify-write. This is the case when the transfer is narrower than four memory beats, or when some byte enables may be clear. Write-data beats pass to the controller's write FIFO, and read-data pop requests pass to the read FIFO. Neither is allowed through until the controller reports that initialization is done. A command whose address is not aligned to its burst size, or whose size code is not supported, is consumed without being issued, and it sets a sticky error flag.

Top module: `mem_req_issuer`

## Requirements
- R1: After reset `req` and `err_sticky` are 0 and `cmd_ready` is 1.
- R2: A supported, aligned command accepted at a clock edge (`cmd_valid` and `cmd_ready` both high) appears on `req`, `req_addr`, `req_rnw` and `req_size` right after that edge. `req_rnw` is 1 for a read and 0 for a write.
- R3: While `req` is high and `ack` is low, the request and all its fields stay unchanged into the next cycle.
- R4: If `ack` is high while `req` is high and no command is offered, `req` is low in the next cycle.
- R5: If a valid command is offered in the same cycle as `ack`, `req` stays high into the next cycle and carries the new command's fields.
- R6: The transfer byte count is PORT_W/8 for size code 0 and 16·2^(code−1) for codes 1 to 5. An address that is not a multiple of this count is not issued and sets `err_sticky`.
- R7: Size codes 6 and 7 are unsupported, and so is code 5 when BIG_BURST_EN is 0. Such a command is not issued and sets `err_sticky`. With the default settings, code 5 is issued normally.
- R8: With ECC_EN=1, a write sets `req_rmw` when its transfer bits are fewer than MEM_DW·4. The transfer bits are PORT_W for code 0 and 128·2^(code−1) otherwise. With the defaults (PORT_W=32, MEM_DW=64), codes 0 and 1 need the read-modify-write and code 2 does not.
- R9: With ECC_EN=1, a write with `cmd_be_full`=0 sets `req_rmw`, whatever its size.
- R10: A read never sets `req_rmw`.
- R11: While `init_done` is 0, `wfifo_push`, `rfifo_pop` and `wr_ready` are 0 whatever the client drives.
- R12: Once `init_done` is 1, `wfifo_push` follows `wr_valid` and `rfifo_pop` follows `rd_want`. Data passes unchanged in little-endian byte order, and `wfifo_be` equals `wr_be` during a push and is 0 otherwise.
- R13: `err_sticky` stays 1 until reset, even while later valid commands are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_done | input | 1 | Controller initialization complete |
| cmd_valid | input | 1 | Local command offered |
| cmd_ready | output | 1 | Command taken at this edge if valid |
| cmd_addr | input | ADDR_W | Command byte address |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_size | input | 3 | Transfer-size code |
| cmd_be_full | input | 1 | All write byte enables will be 1 |
| req | output | 1 | Address-phase request to the controller |
| req_addr | output | ADDR_W | Request address |
| req_rnw | output | 1 | Request direction, 1 = read |
| req_size | output | 3 | Request size code |
| req_rmw | output | 1 | Read-modify-write needed |
| ack | input | 1 | One-cycle acknowledge from the controller |
| err_sticky | output | 1 | Misaligned or unsupported command seen |
| wr_valid | input | 1 | Client write beat offered |
| wr_ready | output | 1 | Write beats may be pushed |
| wr_data | input | PORT_W | Client write beat |
| wr_be | input | PORT_W/8 | Client byte enables |
| wfifo_push | output | 1 | Push into controller write FIFO |
| wfifo_data | output | PORT_W | Write FIFO data |
| wfifo_be | output | PORT_W/8 | Write FIFO byte enables |
| rd_want | input | 1 | Client wants to pop a read beat |
| rfifo_pop | output | 1 | Pop from controller read FIFO |

## Verification
The address phase is tried with single reads and writes of several sizes, each acknowledged after a different random delay. This tells a request that is held steady apart from one that drops or changes before the acknowledge. A back-to-back pair, where the second command arrives in the acknowledge cycle, tells a correct handover apart from a gap cycle or stale fields. The read-modify-write decision is tried across writes with codes 0, 1, 2 and 3 with full and partial byte enables, and across reads, which separates the size rule from the byte-enable rule. Misaligned addresses and unsupported codes, followed by good commands, show that bad commands are dropped and that the error flag stays set. The FIFO gate is driven with pushes and pops both before and after `init_done`.

// File: rtl/mri_pkg.sv
// Shared types and size arithmetic for the memory port request issuer.
// Assumes size codes 1..5 double a 4-word (128-bit) line for each step.
package mri_pkg;
    localparam int SIZE_W = 3;
    typedef logic [SIZE_W-1:0] size_code_t;

    // Number of data bits moved by one transfer of the given code.
    function automatic int unsigned xfer_bits(size_code_t code, int unsigned port_w);
        if (code == '0) return port_w;
        return 32'd128 << (code - 1'b1);
    endfunction

    // True when the code is one the port can issue.
    function automatic logic code_ok(size_code_t code, logic big_en);
        return (code <= 3'd4) || ((code == 3'd5) && big_en);
    endfunction
endpackage

// File: rtl/mri_size_check.sv
// Checks a command's size code and the alignment of its address to the burst.
// Purely combinational; assumes ADDR_W is wide enough for the largest burst.
module mri_size_check
    import mri_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int PORT_W       = 32,
    parameter bit BIG_BURST_EN = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  size_code_t        size,
    output logic              good
);
    logic [ADDR_W-1:0] low_mask;
    logic              supported;

    // Derive the byte mask of the burst and judge the command.
    always_comb begin
        supported = code_ok(size, BIG_BURST_EN);
        low_mask  = ADDR_W'(xfer_bits(size, PORT_W) / 8 - 1);
        good      = supported && ((addr & low_mask) == '0);
    end
endmodule

// File: rtl/mri_rmw_decide.sv
// Decides whether a write must be issued as a read-modify-write.
// Only active when ECC is configured; reads never need it.
module mri_rmw_decide
    import mri_pkg::*;
#(
    parameter int PORT_W = 32,
    parameter int MEM_DW = 64,
    parameter bit ECC_EN = 1'b1
) (
    input  logic       is_read,
    input  size_code_t size,
    input  logic       be_full,
    output logic       rmw
);
    localparam int unsigned MIN_BITS = MEM_DW * 4;

    generate
        if (ECC_EN) begin : g_ecc
            // Short transfers and partial byte coverage both need a merge.
            always_comb rmw = !is_read &&
                              ((xfer_bits(size, PORT_W) < MIN_BITS) || !be_full);
        end else begin : g_no_ecc
            // Without ECC the memory masks bytes itself.
            always_comb rmw = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/mri_addr_phase.sv
// Address-phase register: holds one request until the one-cycle acknowledge,
// and reloads in the acknowledge cycle when another command is waiting.
module mri_addr_phase
    import mri_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ack,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_rnw,
    input  size_code_t        in_size,
    input  logic              in_rmw,
    output logic              open,
    output logic              req,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_rnw,
    output size_code_t        req_size,
    output logic              req_rmw
);
    // A slot is free when idle or when the current request is acknowledged now.
    always_comb open = !req || ack;

    // Load, hold or retire the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req      <= 1'b0;
            req_addr <= '0;
            req_rnw  <= 1'b0;
            req_size <= '0;
            req_rmw  <= 1'b0;
        end else if (load) begin
            req      <= 1'b1;
            req_addr <= in_addr;
            req_rnw  <= in_rnw;
            req_size <= in_size;
            req_rmw  <= in_rmw;
        end else if (ack) begin
            req      <= 1'b0;
        end
    end

    p_hold_until_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(req_addr) && $stable(req_rnw) &&
                           $stable(req_size) && $stable(req_rmw)));

    p_drop_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && !load) |=> !req);

    p_read_no_rmw_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_rnw) |-> !req_rmw);
endmodule

// File: rtl/mri_fifo_gate.sv
// Gates write pushes and read pops on controller initialization.
// Byte enables are forced to zero whenever no push happens.
module mri_fifo_gate #(
    parameter int PORT_W = 32
) (
    input  logic                  init_done,
    input  logic                  wr_valid,
    input  logic [PORT_W-1:0]     wr_data,
    input  logic [PORT_W/8-1:0]   wr_be,
    input  logic                  rd_want,
    output logic                  wr_ready,
    output logic                  wfifo_push,
    output logic [PORT_W-1:0]     wfifo_data,
    output logic [PORT_W/8-1:0]   wfifo_be,
    output logic                  rfifo_pop
);
    // Pass traffic only after initialization.
    always_comb begin
        wr_ready   = init_done;
        wfifo_push = init_done && wr_valid;
        wfifo_data = wr_data;
        wfifo_be   = wfifo_push ? wr_be : '0;
        rfifo_pop  = init_done && rd_want;
    end
endmodule

// File: rtl/mem_req_issuer.sv
// Request issuer for one client port of a multi-port memory controller.
// Runs on the controller clock; validates commands, drives the request/ack
// address phase, flags read-modify-write and gates FIFO traffic on init.
module mem_req_issuer
    import mri_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int PORT_W       = 32,
    parameter int MEM_DW       = 64,
    parameter bit ECC_EN       = 1'b1,
    parameter bit BIG_BURST_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_done,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic                cmd_read,
    input  logic [2:0]          cmd_size,
    input  logic                cmd_be_full,
    output logic                req,
    output logic [ADDR_W-1:0]   req_addr,
    output logic                req_rnw,
    output logic [2:0]          req_size,
    output logic                req_rmw,
    input  logic                ack,
    output logic                err_sticky,
    input  logic                wr_valid,
    output logic                wr_ready,
    input  logic [PORT_W-1:0]   wr_data,
    input  logic [PORT_W/8-1:0] wr_be,
    output logic                wfifo_push,
    output logic [PORT_W-1:0]   wfifo_data,
    output logic [PORT_W/8-1:0] wfifo_be,
    input  logic                rd_want,
    output logic                rfifo_pop
);
    logic cmd_good;
    logic cmd_rmw;
    logic take;
    logic load;

    mri_size_check #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .BIG_BURST_EN(BIG_BURST_EN)) u_chk (
        .addr(cmd_addr), .size(cmd_size), .good(cmd_good)
    );

    mri_rmw_decide #(.PORT_W(PORT_W), .MEM_DW(MEM_DW), .ECC_EN(ECC_EN)) u_rmw (
        .is_read(cmd_read), .size(cmd_size), .be_full(cmd_be_full), .rmw(cmd_rmw)
    );

    // A command is taken whenever the slot is open; only good ones load.
    always_comb begin
        take = cmd_valid && cmd_ready;
        load = take && cmd_good;
    end

    mri_addr_phase #(.ADDR_W(ADDR_W)) u_ap (
        .clk(clk), .rst_n(rst_n), .load(load), .ack(ack),
        .in_addr(cmd_addr), .in_rnw(cmd_read), .in_size(cmd_size), .in_rmw(cmd_rmw),
        .open(cmd_ready), .req(req), .req_addr(req_addr), .req_rnw(req_rnw),
        .req_size(req_size), .req_rmw(req_rmw)
    );

    // Record any rejected command until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                 err_sticky <= 1'b0;
        else if (take && !cmd_good) err_sticky <= 1'b1;
    end

    mri_fifo_gate #(.PORT_W(PORT_W)) u_gate (
        .init_done(init_done), .wr_valid(wr_valid), .wr_data(wr_data), .wr_be(wr_be),
        .rd_want(rd_want), .wr_ready(wr_ready), .wfifo_push(wfifo_push),
        .wfifo_data(wfifo_data), .wfifo_be(wfifo_be), .rfifo_pop(rfifo_pop)
    );

    p_bad_not_issued_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && cmd_valid && !cmd_good) |=> !req);

    p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    p_no_traffic_before_init_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (!wfifo_push && !rfifo_pop));
endmodule

// File: tb/sim_mem_req_issuer.sv
module sim_mem_req_issuer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_done = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic        cmd_read = 1'b0;
    logic [2:0]  cmd_size = '0;
    logic        cmd_be_full = 1'b1;
    logic        req;
    logic [31:0] req_addr;
    logic        req_rnw;
    logic [2:0]  req_size;
    logic        req_rmw;
    logic        ack = 1'b0;
    logic        err_sticky;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        wfifo_push;
    logic [31:0] wfifo_data;
    logic [3:0]  wfifo_be;
    logic        rd_want = 1'b0;
    logic        rfifo_pop;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    mem_req_issuer u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(req == 1'b0, "R1 req", req, 0);
        chk(err_sticky == 1'b0, "R1 err", err_sticky, 0);
        chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    endtask

    // One command, acknowledged after a random delay.
    task automatic t_issue(input logic [31:0] a, input bit rd, input logic [2:0] sz,
                           input bit bf, input bit exp_rmw, input string rtag);
        int unsigned d;
        cmd_addr = a; cmd_read = rd; cmd_size = sz; cmd_be_full = bf; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(req == 1'b1, "R2 req", req, 1);
        chk(req_addr == a && req_rnw == rd && req_size == sz, "R2 fields",
            {req_addr, req_rnw, req_size}, {a, rd, sz});
        chk(req_rmw == exp_rmw, rtag, req_rmw, exp_rmw);
        d = $urandom_range(0, 4);
        for (int i = 0; i < int'(d); i++) begin
            @(negedge clk);
            chk(req == 1'b1 && req_addr == a && req_size == sz && req_rmw == exp_rmw,
                "R3 hold", {req, req_addr}, {1'b1, a});
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(req == 1'b0, "R4 drop", req, 0);
    endtask

    task automatic t_back2back();
        cmd_addr = 32'h40; cmd_read = 1'b1; cmd_size = 3'd1; cmd_be_full = 1'b1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        ack = 1'b1;
        cmd_addr = 32'h80; cmd_read = 1'b0; cmd_size = 3'd2; cmd_be_full = 1'b1; cmd_valid = 1'b1;
        @(negedge clk);
        ack = 1'b0; cmd_valid = 1'b0;
        chk(req == 1'b1 && req_addr == 32'h80 && req_rnw == 1'b0 && req_size == 3'd2,
            "R5 next", {req, req_addr, req_size}, {1'b1, 32'h80, 3'd2});
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(req == 1'b0, "R4 drop after pair", req, 0);
    endtask

    task automatic t_reject(input logic [31:0] a, input logic [2:0] sz, input string rtag);
        cmd_addr = a; cmd_read = 1'b0; cmd_size = sz; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(req == 1'b0, {rtag, " not issued"}, req, 0);
        chk(err_sticky == 1'b1, {rtag, " err"}, err_sticky, 1);
    endtask

    task automatic t_fifo_gate();
        init_done = 1'b0; wr_valid = 1'b1; wr_data = 32'hA1B2C3D4; wr_be = 4'b0101; rd_want = 1'b1;
        @(negedge clk);
        chk(wfifo_push == 1'b0 && rfifo_pop == 1'b0 && wr_ready == 1'b0, "R11 gated",
            {wfifo_push, rfifo_pop, wr_ready}, 0);
        init_done = 1'b1;
        @(negedge clk);
        chk(wfifo_push == 1'b1 && rfifo_pop == 1'b1, "R12 open", {wfifo_push, rfifo_pop}, 3);
        chk(wfifo_data == 32'hA1B2C3D4 && wfifo_be == 4'b0101, "R12 data",
            {wfifo_data, wfifo_be}, {32'hA1B2C3D4, 4'b0101});
        wr_valid = 1'b0; rd_want = 1'b0;
        @(negedge clk);
        chk(wfifo_push == 1'b0 && wfifo_be == 4'b0 && rfifo_pop == 1'b0, "R12 idle",
            {wfifo_push, wfifo_be, rfifo_pop}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        chk(wfifo_push == 1'b0 && rfifo_pop == 1'b0, "R11 reset", {wfifo_push, rfifo_pop}, 0);
        t_issue(32'h0000_0004, 1'b0, 3'd0, 1'b1, 1'b1, "R8 code0 rmw");
        t_issue(32'h0000_0010, 1'b0, 3'd1, 1'b1, 1'b1, "R8 code1 rmw");
        t_issue(32'h0000_0020, 1'b0, 3'd2, 1'b1, 1'b0, "R8 code2 no rmw");
        t_issue(32'h0000_0040, 1'b0, 3'd3, 1'b0, 1'b1, "R9 partial be");
        t_issue(32'h0000_0008, 1'b1, 3'd0, 1'b0, 1'b0, "R10 read");
        t_issue(32'h0000_0080, 1'b1, 3'd4, 1'b1, 1'b0, "R10 read code4");
        t_issue(32'h0000_0100, 1'b1, 3'd5, 1'b1, 1'b0, "R7 code5 ok");
        t_back2back();
        t_reject(32'h0000_0104, 3'd2, "R6 misaligned");
        t_issue(32'h0000_0200, 1'b1, 3'd3, 1'b1, 1'b0, "R10 after err");
        chk(err_sticky == 1'b1, "R13 sticky", err_sticky, 1);
        t_reset_state();
        t_reject(32'h0000_0000, 3'd6, "R7 code6");
        do_reset();
        t_reject(32'h0000_0000, 3'd7, "R7 code7");
        t_fifo_gate();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule